// File: doc/BRIEF.md
# Timer Compare Match Unit

This block holds a 16-bit up/down timer and one compare channel watching it. Each enabled cycle the timer steps up or down by one and wraps modulo 2^16. When a counting step lands the timer on the programmed compare value, the block emits a one-cycle match pulse and sets a sticky pending flag. Software clears that flag by writing 1 to its clear bit.

The timer can also be written directly by software or cleared to zero by a reset request from a neighbouring capture channel. Neither of these ever produces a match, even when the new timer value equals the compare value. The match is triggered only by a counting step.

When a software write and a channel reset arrive in the same cycle, the reset wins. A sticky collision flag records that the clash happened.

Top module: `cmp_match_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the timer, the compare value, `match`, `pend` and `coll` all become 0.
- R2: With `cnt_en` high and neither `ld_we` nor `chan_rst` high, the timer steps by one at each edge. It counts up when `cnt_up` is 1 and down when `cnt_up` is 0, and wraps modulo 2^16 (0xFFFF up goes to 0, and 0 down goes to 0xFFFF). With `cnt_en` low it holds.
- R3: `ld_we` high, with `chan_rst` low, loads `ld_val` into the timer at the edge. The load takes priority over counting.
- R4: `chan_rst` high clears the timer to 0 at the edge. It takes priority over both load and counting.
- R5: `chan_rst` and `ld_we` high in the same cycle set the sticky flag `coll`. Writing 1 to `flag_clr[1]` clears it, and a new clash in that same cycle wins over the clear.
- R6: `match` is high for exactly the one cycle after an edge at which the timer stepped by counting onto the compare value. In that cycle `tmr` already shows the new value.
- R7: A load that places the timer equal to the compare value produces no match.
- R8: A channel reset to 0 with a compare value of 0 produces no match. Counting onto 0, including by wraparound, does produce a match.
- R9: `pend` becomes 1 at the edge after a cycle with `match` high, and stays 1 until `flag_clr[0]` is written as 1. A match in the same cycle as that clear wins.
- R10: `cmp_we` loads `cmp_val` at the edge. A counting step in that same cycle is compared against the previous compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Timer count enable |
| cnt_up | input | 1 | Count direction: 1 up, 0 down |
| ld_we | input | 1 | Software timer write strobe |
| ld_val | input | 16 | Software timer write value |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_val | input | 16 | Compare value |
| chan_rst | input | 1 | Timer reset request from a capture channel |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 pending, bit 1 collision |
| match | output | 1 | One-cycle match pulse |
| pend | output | 1 | Sticky match pending flag |
| coll | output | 1 | Sticky write/reset collision flag |
| tmr | output | 16 | Current timer value |

## Verification
A wrong timer value shows on `tmr` one cycle after the faulty edge. It also shifts every later match to a different cycle or suppresses it altogether.

A comparator that also looks at loaded or reset values shows up as a spurious `match` in the cycle right after the load or reset. One cycle later it shows as a spurious `pend`.

A wrong clear/set priority shows on `pend` or `coll` one cycle after the edge where a clear and a new event coincide.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
    parameter int TW = 16;

    localparam int CLR_PEND = 0;
    localparam int CLR_COLL = 1;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_UP,
        ACT_DN,
        ACT_LOAD,
        ACT_ZERO
    } act_e;

    typedef struct packed {
        logic pend;
        logic coll;
    } flags_t;

    // Fixed priority: channel reset, then software load, then counting.
    function automatic act_e pick_act(input logic rst_req, input logic ld,
                                      input logic en, input logic up);
        if (rst_req)  return ACT_ZERO;
        else if (ld)  return ACT_LOAD;
        else if (en)  return up ? ACT_UP : ACT_DN;
        else          return ACT_HOLD;
    endfunction
endpackage

// File: rtl/cmu_timer.sv
module cmu_timer
    import cmu_pkg::*;
#(
    parameter int W = cmu_pkg::TW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         cnt_up,
    input  logic         ld_we,
    input  logic [W-1:0] ld_val,
    input  logic         chan_rst,
    output logic [W-1:0] tmr_q,
    output logic [W-1:0] step_nxt,
    output logic         step_go,
    output logic         clash
);
    localparam logic [W-1:0] ONE = W'(1);

    act_e act;

    always_comb begin
        act      = pick_act(chan_rst, ld_we, cnt_en, cnt_up);
        step_nxt = cnt_up ? tmr_q + ONE : tmr_q - ONE;
        step_go  = (act == ACT_UP) || (act == ACT_DN);
        clash    = chan_rst & ld_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            case (act)
                ACT_ZERO:        tmr_q <= '0;
                ACT_LOAD:        tmr_q <= ld_val;
                ACT_UP, ACT_DN:  tmr_q <= step_nxt;
                default:         tmr_q <= tmr_q;
            endcase
        end
    end

    a_r4_reset_zero: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> (tmr_q == '0));
    a_r3_load_value: assert property (@(posedge clk) disable iff (rst)
        (ld_we && !chan_rst) |=> (tmr_q == $past(ld_val)));
    a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_up && !ld_we && !chan_rst) |=> (tmr_q == $past(tmr_q) + ONE));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !ld_we && !chan_rst) |=> $stable(tmr_q));
endmodule

// File: rtl/cmu_compare.sv
module cmu_compare #(
    parameter int W = cmu_pkg::TW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_val,
    input  logic         step_go,
    input  logic [W-1:0] step_nxt,
    output logic         match_q
);
    logic [W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q   <= '0;
            match_q <= 1'b0;
        end else begin
            if (cmp_we) cmp_q <= cmp_val;
            match_q <= step_go && (step_nxt == cmp_q);
        end
    end

    a_r10_cmp_load: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> (cmp_q == $past(cmp_val)));
endmodule

// File: rtl/cmu_flags.sv
module cmu_flags
    import cmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       match_q,
    input  logic       clash,
    input  logic [1:0] flag_clr,
    output flags_t     flg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flg <= '0;
        end else begin
            flg.pend <= (flg.pend & ~flag_clr[CLR_PEND]) | match_q;
            flg.coll <= (flg.coll & ~flag_clr[CLR_COLL]) | clash;
        end
    end

    a_r9_pend_set: assert property (@(posedge clk) disable iff (rst)
        match_q |=> flg.pend);
    a_r9_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        (flg.pend && !flag_clr[CLR_PEND]) |=> flg.pend);
    a_r5_coll_set: assert property (@(posedge clk) disable iff (rst)
        clash |=> flg.coll);
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
    import cmu_pkg::*;
#(
    parameter int W = cmu_pkg::TW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         cnt_up,
    input  logic         ld_we,
    input  logic [W-1:0] ld_val,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_val,
    input  logic         chan_rst,
    input  logic [1:0]   flag_clr,
    output logic         match,
    output logic         pend,
    output logic         coll,
    output logic [W-1:0] tmr
);
    logic [W-1:0] step_nxt;
    logic         step_go;
    logic         clash;
    flags_t       flg;

    cmu_timer #(.W(W)) u_tmr (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .ld_we(ld_we), .ld_val(ld_val), .chan_rst(chan_rst),
        .tmr_q(tmr), .step_nxt(step_nxt), .step_go(step_go), .clash(clash)
    );

    cmu_compare #(.W(W)) u_cmp (
        .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_val(cmp_val),
        .step_go(step_go), .step_nxt(step_nxt), .match_q(match)
    );

    cmu_flags u_flg (
        .clk(clk), .rst(rst), .match_q(match), .clash(clash),
        .flag_clr(flag_clr), .flg(flg)
    );

    assign pend = flg.pend;
    assign coll = flg.coll;

    // R7 and R8: a load or a channel reset never yields a match
    a_r7_no_match_on_write: assert property (@(posedge clk) disable iff (rst)
        (ld_we || chan_rst) |=> !match);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!match && !pend && !coll && tmr == '0));
endmodule

// File: tb/sim_cmp_match_unit.sv
module sim_cmp_match_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 0, cnt_up = 0, ld_we = 0, cmp_we = 0, chan_rst = 0;
    logic [15:0] ld_val = 0, cmp_val = 0;
    logic [1:0]  flag_clr = 0;
    logic        match, pend, coll;
    logic [15:0] tmr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cmp_match_unit u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .ld_we(ld_we), .ld_val(ld_val), .cmp_we(cmp_we), .cmp_val(cmp_val),
        .chan_rst(chan_rst), .flag_clr(flag_clr),
        .match(match), .pend(pend), .coll(coll), .tmr(tmr)
    );

    typedef struct packed {
        logic        en;
        logic        up;
        logic        ldw;
        logic [15:0] ldv;
        logic        cw;
        logic [15:0] cv;
        logic        rs;
        logic [1:0]  clr;
        logic [15:0] et;
        logic        em;
        logic        ep;
        logic        ec;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{0,0,0,16'h0000,1,16'h0005,0,2'b00,16'h0000,0,0,0,8'd10}, // set cmp 5
        '{0,0,1,16'h0003,0,16'h0000,0,2'b00,16'h0003,0,0,0,8'd3},  // load 3
        '{1,1,0,16'h0000,0,16'h0000,0,2'b00,16'h0004,0,0,0,8'd2},  // up to 4
        '{1,1,0,16'h0000,0,16'h0000,0,2'b00,16'h0005,1,0,0,8'd6},  // up onto 5: match
        '{0,0,0,16'h0000,0,16'h0000,0,2'b00,16'h0005,0,1,0,8'd9},  // pend set
        '{0,0,0,16'h0000,0,16'h0000,0,2'b01,16'h0005,0,0,0,8'd9},  // clear pend
        '{0,0,1,16'h0005,0,16'h0000,0,2'b00,16'h0005,0,0,0,8'd7},  // load equal cmp
        '{1,0,0,16'h0000,0,16'h0000,0,2'b00,16'h0004,0,0,0,8'd2},  // down to 4
        '{1,1,0,16'h0000,0,16'h0000,0,2'b00,16'h0005,1,0,0,8'd6},  // up onto 5
        '{1,1,0,16'h0000,0,16'h0000,0,2'b01,16'h0006,0,1,0,8'd9},  // set beats clear
        '{0,0,0,16'h0000,0,16'h0000,0,2'b01,16'h0006,0,0,0,8'd9},  // clear
        '{0,0,0,16'h0000,1,16'h0000,0,2'b00,16'h0006,0,0,0,8'd10}, // cmp 0
        '{1,1,0,16'h0000,0,16'h0000,1,2'b00,16'h0000,0,0,0,8'd8},  // reset to 0: no match
        '{0,0,1,16'h0001,0,16'h0000,0,2'b00,16'h0001,0,0,0,8'd3},  // load 1
        '{1,0,0,16'h0000,0,16'h0000,0,2'b00,16'h0000,1,0,0,8'd8},  // count onto 0
        '{1,0,0,16'h0000,0,16'h0000,0,2'b00,16'hFFFF,0,1,0,8'd2},  // wrap down
        '{1,1,0,16'h0000,0,16'h0000,0,2'b00,16'h0000,1,1,0,8'd8},  // wrap up onto 0
        '{1,1,1,16'h0007,0,16'h0000,1,2'b01,16'h0000,0,1,1,8'd5},  // clash, reset wins
        '{0,0,0,16'h0000,0,16'h0000,0,2'b11,16'h0000,0,0,0,8'd5},  // clear both
        '{1,1,0,16'h0000,1,16'h0002,0,2'b00,16'h0001,0,0,0,8'd10}, // cmp 2 while stepping
        '{1,1,0,16'h0000,1,16'h0001,0,2'b00,16'h0002,1,0,0,8'd10}, // old cmp 2 matches
        '{1,1,1,16'h0009,0,16'h0000,0,2'b00,16'h0009,0,1,0,8'd3},  // load beats count
        '{0,1,0,16'h0000,0,16'h0000,0,2'b00,16'h0009,0,1,0,8'd2}   // hold
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cnt_en = v.en; cnt_up = v.up; ld_we = v.ldw; ld_val = v.ldv;
        cmp_we = v.cw; cmp_val = v.cv; chan_rst = v.rs; flag_clr = v.clr;
    endtask

    task automatic idle();
        cnt_en = 0; ld_we = 0; cmp_we = 0; chan_rst = 0; flag_clr = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "tmr", 32'(tmr), 0);
        chk("R1", "flags", {match, pend, coll}, 0);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            drive(TBL[i]);
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
            chk(tag, "tmr", 32'(tmr), 32'(TBL[i].et));
            chk(tag, "match", 32'(match), 32'(TBL[i].em));
            chk(tag, "pend", 32'(pend), 32'(TBL[i].ep));
            chk(tag, "coll", 32'(coll), 32'(TBL[i].ec));
        end
        idle();

        // R6: pulse lasts exactly one cycle while counting stays on
        ld_we = 1; ld_val = 16'h0000; cmp_we = 1; cmp_val = 16'h0003;
        @(negedge clk);
        idle(); cnt_en = 1; cnt_up = 1;
        repeat (3) @(negedge clk);
        chk("R6", "match at 3", 32'(match), 1);
        @(negedge clk);
        chk("R6", "match gone at 4", 32'(match), 0);
        chk("R6", "tmr", 32'(tmr), 4);
        idle();

        // R1: mid-run reset clears timer, flags and compare value
        rst = 1;
        @(negedge clk);
        chk("R1", "tmr after reset", 32'(tmr), 0);
        chk("R1", "flags after reset", {match, pend, coll}, 0);
        rst = 0;
        ld_we = 1; ld_val = 16'hFFFF;
        @(negedge clk);
        idle(); cnt_en = 1; cnt_up = 1;
        @(negedge clk);
        idle();
        chk("R1", "cmp reset to 0 gives wrap match", 32'(match), 1);

        // R2: long hold is stable
        repeat (20) @(negedge clk);
        chk("R2", "hold", 32'(tmr), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule